// File: doc/BRIEF.md
# Polarity-safe SPI chip-select sequencer

This block is the front end of an SPI master that talks to several slave devices. Each device can use a different clock mode. Chip selects are plain active-low outputs, one per device. A shift-register slave treats any clock transition inside its select window as a real shift. If the clock idle level flipped after that slave had been selected, every bit it receives would land one position late.

To prevent this, the sequencer keeps a record of the level at which SCLK currently rests. When a transaction is accepted, it reads the target device's CPOL and CPHA from a per-device mode table. If the target needs the other idle level, the block first runs a settle step. SCLK moves to the new level while every select is high, and stays there for at least one full SCLK period. Only after that is the chosen select pulled low. When the idle level already matches, the select goes low at once. Bytes then shift MSB first, under the usual four SPI mode rules, and the half-period comes from a runtime divider. A transaction is a sequence of bytes on a valid/ready stream, and a last flag on a byte closes it. Each received byte is returned with a one-cycle valid strobe, and a done pulse marks the release of the select.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset every bit of `cs_n` is 1, `sclk` is 0, `mosi` is 0, `tx_ready` is 1, and `done` and `rx_valid` are 0. The stored idle level is 0.
- R2: The level of `sclk` changes only while all of `cs_n` is 1 or while bits are shifting. Device i's CPOL is `dev_mode[2i+1]`. When it differs from the stored idle level, `sclk` takes the new level in the cycle after acceptance and holds it for 2·(clk_div+1) cycles before any select goes low.
- R3: No more than one bit of `cs_n` is 0 at a time. The bit that goes low is the one indexed by the `tx_dev` value sampled when the first byte was accepted.
- R4: When the device's CPOL equals the stored idle level, no settle step runs. The select goes low in the cycle after the first byte is accepted.
- R5: From the cycle the select goes low, or the cycle after a later byte is accepted, `sclk` holds its idle level for clk_div+1 cycles. It then holds for a further clk_div+1 cycles before the first edge.
- R6: Bits go out MSB first. Device i's CPHA is `dev_mode[2i]`. With CPHA 0, `mosi` presents the MSB from acceptance, changes on trailing edges, and `miso` is sampled on leading edges. With CPHA 1, `mosi` is 0 from acceptance, changes on leading edges, and sampling is on trailing edges. After the last bit, `mosi` keeps its value.
- R7: In the cycle after the 16th edge of a byte, `rx_valid` is 1 for one cycle, and `rx_data` holds the 8 sampled bits, the first sample in the MSB.
- R8: If a byte has `tx_last` 0, the select stays low and `sclk` rests at its idle level until the next byte is accepted. The `tx_dev` value offered with that next byte is ignored.
- R9: After the last byte's final edge, the select stays low for clk_div+1 cycles. Then all of `cs_n` returns to 1 and `done` is 1 for exactly that cycle.
- R10: Every SCLK half-period during shifting lasts clk_div+1 clock cycles.
- R11: `tx_ready` is 1 only while the block is idle or waiting between bytes. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | SCLK half-period length minus one, in clock cycles |
| dev_mode | input | 2·NUM_DEV | Per-device mode table, {CPOL, CPHA} for device i at bits 2i+1 and 2i |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be accepted |
| tx_dev | input | IDX_W | Target device, used with the first byte of a transaction |
| tx_data | input | DATA_W | Byte to send |
| tx_last | input | 1 | Byte closes the transaction |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Received byte |
| done | output | 1 | Pulse on select release |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_DEV | Active-low chip selects |

## Verification
The bench builds the block with NUM_DEV=4 and DATA_W=8, and the mode table gives the four devices the four SPI modes. This lets one run cover settle steps from low to high and from high to low, a same-level hand-off with no settle step, and a multi-byte transaction with a changed device index on a later byte. The divider is changed between transactions to 1, 0 and 3. Setting 0 gives single-cycle half-periods, where the setup, hold and settle windows are shortest and any off-by-one in their counters shows up.

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer #(
  parameter int NUM_DEV = 4,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     clk_div,
  input  logic [2*NUM_DEV-1:0] dev_mode,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [IDX_W-1:0]     tx_dev,
  input  logic [DATA_W-1:0]    tx_data,
  input  logic                 tx_last,
  output logic                 rx_valid,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 done,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic [NUM_DEV-1:0]   cs_n
);
  localparam int CNT_W = DIV_W + 1;
  localparam int HC_W  = $clog2(2*DATA_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_SETUP, S_SHIFT, S_NEXT, S_HOLD} st_t;
  st_t state;

  logic [CNT_W-1:0]  cnt;
  logic [HC_W-1:0]   hc;
  logic [DATA_W-1:0] txb, rxb;
  logic [IDX_W-1:0]  dev_q;
  logic              idle_pol, cpha_q, last_q;

  wire              half_end = (cnt == {1'b0, clk_div});
  wire              full_end = (cnt == {clk_div, 1'b1});
  wire              sel_cpol = dev_mode[{tx_dev, 1'b1}];
  wire              sel_cpha = dev_mode[{tx_dev, 1'b0}];
  wire [HC_W-2:0]   bit_idx  = hc[HC_W-1:1];
  wire              lead     = ~hc[0];
  wire              samp     = lead ^ cpha_q;
  wire              final_e  = (hc == HC_W'(2*DATA_W-1));
  wire [DATA_W-1:0] sh_cur   = txb << bit_idx;
  wire [DATA_W-1:0] sh_nxt   = txb << (bit_idx + 1'b1);
  wire [DATA_W-1:0] rx_in    = {rxb[DATA_W-2:0], miso};

  assign tx_ready = (state == S_IDLE) || (state == S_NEXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      hc       <= '0;
      txb      <= '0;
      rxb      <= '0;
      dev_q    <= '0;
      idle_pol <= 1'b0;
      cpha_q   <= 1'b0;
      last_q   <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      cs_n     <= '1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      done     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE: if (tx_valid) begin
          dev_q  <= tx_dev;
          cpha_q <= sel_cpha;
          txb    <= tx_data;
          last_q <= tx_last;
          mosi   <= sel_cpha ? 1'b0 : tx_data[DATA_W-1];
          cnt    <= '0;
          if (sel_cpol != idle_pol) begin
            idle_pol <= sel_cpol;
            sclk     <= sel_cpol;
            state    <= S_SETTLE;
          end else begin
            cs_n  <= ~(NUM_DEV'(1) << tx_dev);
            state <= S_SETUP;
          end
        end
        S_SETTLE: if (full_end) begin
          cnt   <= '0;
          cs_n  <= ~(NUM_DEV'(1) << dev_q);
          state <= S_SETUP;
        end else cnt <= cnt + 1'b1;
        S_SETUP: if (half_end) begin
          cnt   <= '0;
          hc    <= '0;
          state <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (half_end) begin
          cnt  <= '0;
          sclk <= ~sclk;
          hc   <= hc + 1'b1;
          if (samp) rxb <= rx_in;
          else if (cpha_q) mosi <= sh_cur[DATA_W-1];
          else if (!final_e) mosi <= sh_nxt[DATA_W-1];
          if (final_e) begin
            rx_valid <= 1'b1;
            rx_data  <= samp ? rx_in : rxb;
            state    <= last_q ? S_HOLD : S_NEXT;
          end
        end else cnt <= cnt + 1'b1;
        S_NEXT: if (tx_valid) begin
          txb    <= tx_data;
          last_q <= tx_last;
          mosi   <= cpha_q ? 1'b0 : tx_data[DATA_W-1];
          cnt    <= '0;
          state  <= S_SETUP;
        end
        S_HOLD: if (half_end) begin
          cnt   <= '0;
          cs_n  <= '1;
          done  <= 1'b1;
          state <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_sequencer_chk.sv
module spi_cs_sequencer_chk #(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sclk,
  input logic [NUM_DEV-1:0] cs_n,
  input logic               done,
  input logic               tx_ready,
  input logic               rx_valid
);
  wire all_hi = &cs_n;

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_level_at_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && $past(all_hi)) |-> (sclk == $past(sclk)));

  p_setup_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && $past(all_hi)) |=> $stable(sclk));

  p_release_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (all_hi && !$past(all_hi)) |-> done);

  p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> all_hi);

  p_ready_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tx_ready);

  p_rx_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind spi_cs_sequencer spi_cs_sequencer_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
  .done(done), .tx_ready(tx_ready), .rx_valid(rx_valid)
);

// File: tb/tb_spi_cs_sequencer.sv
`timescale 1ns/1ps
module tb_spi_cs_sequencer;
  localparam int NUM_DEV = 4;
  localparam int DATA_W  = 8;
  localparam int DIV_W   = 8;
  localparam int IDX_W   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0]     clk_div = 8'd1;
  logic [2*NUM_DEV-1:0] dev_mode = 8'b01_11_10_00;
  logic tx_valid = 1'b0, tx_last = 1'b0, miso = 1'b0;
  logic [IDX_W-1:0]  tx_dev = '0;
  logic [DATA_W-1:0] tx_data = '0;
  logic tx_ready, rx_valid, done, sclk, mosi;
  logic [DATA_W-1:0]  rx_data;
  logic [NUM_DEV-1:0] cs_n;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  spi_cs_sequencer #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .dev_mode(dev_mode),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dev(tx_dev), .tx_data(tx_data),
    .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  typedef struct packed {
    logic sclk; logic [NUM_DEV-1:0] csn; logic mosi; logic rxv; logic done; logic samp;
  } ent_t;

  ent_t q[$];
  ent_t cur;
  logic m_lvl, m_intxn, m_cph, m_ready;
  logic [NUM_DEV-1:0] m_csn;
  logic [DATA_W-1:0]  m_rx;

  function automatic ent_t mk(logic s, logic [NUM_DEV-1:0] c, logic m, logic rv, logic dn, logic sp);
    ent_t e; e.sclk = s; e.csn = c; e.mosi = m; e.rxv = rv; e.done = dn; e.samp = sp; return e;
  endfunction

  task automatic gen(input int dev, input logic [DATA_W-1:0] d, input logic last);
    int h; logic m;
    h = int'(clk_div) + 1;
    if (!m_intxn) begin
      m_cph = dev_mode[2*dev];
      m_csn = ~(NUM_DEV'(1) << dev);
    end
    m = m_cph ? 1'b0 : d[DATA_W-1];
    if (!m_intxn && dev_mode[2*dev+1] != m_lvl) begin
      m_lvl = dev_mode[2*dev+1];
      for (int j = 0; j < 2*h; j++) q.push_back(mk(m_lvl, '1, m, 0, 0, 0));
    end
    for (int j = 0; j < h; j++) q.push_back(mk(m_lvl, m_csn, m, 0, 0, 0));
    for (int k = 0; k < 2*DATA_W; k++) begin
      bit smp = ((k % 2) == 0) ^ m_cph;
      for (int j = 0; j < h; j++)
        q.push_back(mk(m_lvl ^ logic'(k % 2), m_csn, m, 0, 0, (j == h-1) && smp));
      if (!smp) begin
        if (m_cph) m = d[DATA_W-1-k/2];
        else if (k != 2*DATA_W-1) m = d[DATA_W-2-k/2];
      end
    end
    if (last) begin
      for (int j = 0; j < h; j++) q.push_back(mk(m_lvl, m_csn, m, j == 0, 0, 0));
      q.push_back(mk(m_lvl, '1, m, 0, 1, 0));
      m_intxn = 0;
    end else begin
      q.push_back(mk(m_lvl, m_csn, m, 1, 0, 0));
      m_intxn = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur = mk(0, '1, 0, 0, 0, 0);
      m_lvl = 0; m_intxn = 0; m_cph = 0; m_ready = 1; m_rx = '0; m_csn = '1;
    end else begin
      if (cur.samp) m_rx = {m_rx[DATA_W-2:0], miso};
      if (q.size() == 0 && tx_valid) gen(int'(tx_dev), tx_data, tx_last);
      if (q.size() > 0) cur = q.pop_front();
      else begin cur.rxv = 0; cur.done = 0; cur.samp = 0; end
      m_ready = (q.size() == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
    if (rst_n && !finished) begin
      chk("R2 R5 R10 sclk", 32'(sclk), 32'(cur.sclk));
      chk("R3 R4 R8 R9 cs_n", 32'(cs_n), 32'(cur.csn));
      chk("R6 mosi", 32'(mosi), 32'(cur.mosi));
      chk("R7 rx_valid", 32'(rx_valid), 32'(cur.rxv));
      if (cur.rxv) chk("R7 rx_data", 32'(rx_data), 32'(m_rx));
      chk("R9 done", 32'(done), 32'(cur.done));
      chk("R11 tx_ready", 32'(tx_ready), 32'(m_ready));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic send(input int dev, input logic [DATA_W-1:0] d, input logic last);
    @(negedge clk);
    tx_valid = 1; tx_dev = IDX_W'(dev); tx_data = d; tx_last = last;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values, checked before release
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 32'h0);
    chk("R1 mosi", 32'(mosi), 32'h0);
    chk("R1 tx_ready", 32'(tx_ready), 32'h1);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 rx_valid", 32'(rx_valid), 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R4: mode 0 device, idle level already 0
    send(0, 8'hA5, 1); wait_done();
    // R2: mode 2 device needs settle to 1
    send(1, 8'h3C, 1); wait_done();
    // R4 R8: mode 3 device, same level, two bytes, tx_dev changed on byte 2
    send(2, 8'h81, 0); send(0, 8'h7E, 1); wait_done();
    // R10: shortest half-period, settle back to 0 on mode 1 device
    clk_div = 8'd0;
    send(3, 8'hC3, 0); send(1, 8'h5A, 0); send(2, 8'h0F, 1); wait_done();
    clk_div = 8'd3;
    send(0, 8'hFF, 0); send(3, 8'h00, 1); wait_done();
    send(1, 8'h96, 1); wait_done();
    send(2, 8'h69, 1); wait_done();
    clk_div = 8'd0;
    send(0, 8'h12, 1); wait_done();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule